// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Grant Parking

This block is the central arbiter for a shared parallel bus with several masters. Each master has its own active-low request line and its own active-low grant line. The arbiter picks one requester at a time in round-robin order. When nobody is requesting, it keeps a grant on one device, so that device can start at once. The arbiter also watches the shared active-low cycle-framing and initiator-ready lines. From these it learns which master actually started a transaction, and that master then moves to the back of the priority order.

The grant is allowed to move while a transaction is still on the bus. This hides arbitration behind data transfer. A master that loses its grant finishes its current transaction but may not begin another one. Any handover from one master to another passes through exactly one clock in which no grant is driven.

All pins are plain control lines. No data flows through the block, so it has no valid/ready interface.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle.
- R2: While `rst_n` is low, and right after it rises, device 0 holds the grant. The round-robin order then starts at device 0 (0, 1, 2, ...).
- R3: If no bit of `req_n` is low, a held grant stays where it is. If no grant is held, the grant goes back to the device that was last given a grant, so it is parked there.
- R4: A grant never moves directly from one device to another. The old grant drops, exactly one clock follows with every `gnt_n` bit high, and then the new grant is driven.
- R5: The winner is the first requesting device in cyclic index order that starts just after the served master. The served master is the device that most recently started a transaction, and it has the lowest priority.
- R6: The bus is busy whenever `frame_n` or `irdy_n` is low, and idle only when both are high. A transaction start is a clock with `frame_n` low that follows an idle clock. At a start, the served master becomes the device whose `gnt_n` was low one clock before the clock in which `frame_n` first went low. No other event changes the served master.
- R7: Grant handover does not wait for the bus to go idle. It proceeds while `frame_n` or `irdy_n` is low.
- R8: A grant holder that is still requesting loses its grant when the round-robin winner is another requesting device.
- R9: While the grant holder is the round-robin winner, its grant stays asserted without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NUM_MASTERS | Per-device bus request, active low, bit i belongs to device i |
| frame_n | input | 1 | Shared cycle-framing line, active low |
| irdy_n | input | 1 | Shared initiator-ready line, active low |
| gnt_n | output | NUM_MASTERS | Per-device bus grant, active low, bit i belongs to device i |

## Verification
Requests are applied in several patterns:
- A single requester on an idle bus. This separates an idle hold from a one-gap handover.
- Two or four devices requesting at once after different served masters. This shows whether the rotation base is the last started transaction, and whether the index wraps from the top device to device 0.
- Requests that change while the framing or ready lines are low. These show that handover does not wait for an idle bus.
- Runs with all requests released. These tell holding apart from parking back on the last target after a gap.

A mid-run reset followed by two competing requests shows that the order restarts at device 0.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Action chosen by the grant register for the next clock.
  typedef enum logic [1:0] {
    GA_HOLD = 2'd0,  // keep the current grant
    GA_DROP = 2'd1,  // release the grant, entering the one-clock gap
    GA_GIVE = 2'd2,  // drive the grant to the round-robin winner
    GA_PARK = 2'd3   // no requester: return the grant to the last target
  } gnt_act_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          any_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N-1:0]  win_oh_o
);

  localparam int SW = IW + 1;

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [SW-1:0]  start;
  logic [SW-1:0]  slot;

  assign dbl   = {req_i, req_i};
  assign start = {1'b0, base_i} + SW'(1);
  // rot[0] is the device just after the base; rot[N-1] is the base itself
  assign rot   = dbl[start +: N];

  always_comb begin
    any_o     = 1'b0;
    win_idx_o = '0;
    slot      = '0;
    for (int k = 0; k < N; k++) begin
      if (!any_o && rot[k]) begin
        any_o = 1'b1;
        slot  = {1'b0, base_i} + SW'(k + 1);
        if (slot >= SW'(N)) slot = slot - SW'(N);
        win_idx_o = slot[IW-1:0];
      end
    end
  end

  assign win_oh_o = any_o ? (N'(1) << win_idx_o) : '0;

endmodule

// File: rtl/arb_bus_monitor.sv
module arb_bus_monitor #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic [N-1:0]  gnt_oh_i,
  output logic [IW-1:0] served_o
);

  logic          idle_q;
  logic [N-1:0]  prev_gnt_q;
  logic [IW-1:0] served_q;
  logic [IW-1:0] prev_idx;
  logic          start_seen;

  // A start is the first clock of framing after an idle clock.
  assign start_seen = idle_q && !frame_n_i;

  always_comb begin
    prev_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (prev_gnt_q[k]) prev_idx = IW'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q     <= 1'b1;
      prev_gnt_q <= '0;
      served_q   <= IW'(N - 1);
    end else begin
      idle_q     <= frame_n_i && irdy_n_i;
      prev_gnt_q <= gnt_oh_i;
      if (start_seen && (prev_gnt_q != '0)) served_q <= prev_idx;
    end
  end

  assign served_o = served_q;

  AST_SERVED_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_seen |=> $stable(served_q)); // R6

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
  import bus_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_req_i,
  input  logic [IW-1:0] win_idx_i,
  input  logic [N-1:0]  win_oh_i,
  output logic [N-1:0]  gnt_oh_o
);

  logic [N-1:0]  gnt_q;
  logic [IW-1:0] tgt_q;
  gnt_act_e      act;

  always_comb begin
    if (gnt_q == '0)                            act = any_req_i ? GA_GIVE : GA_PARK;
    else if (any_req_i && (gnt_q != win_oh_i)) act = GA_DROP;
    else                                       act = GA_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= N'(1);
      tgt_q <= '0;
    end else begin
      unique case (act)
        GA_GIVE: begin
          gnt_q <= win_oh_i;
          tgt_q <= win_idx_i;
        end
        GA_PARK: gnt_q <= N'(1) << tgt_q;
        GA_DROP: gnt_q <= '0;
        default: gnt_q <= gnt_q;
      endcase
    end
  end

  assign gnt_oh_o = gnt_q;

  AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_q) <= 1); // R1
  AST_GAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0) |=> (gnt_q != '0)); // R4
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |=> ((gnt_q == '0) || $stable(gnt_q))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req_i && (gnt_q != '0)) |=> $stable(gnt_q)); // R3

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_n,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  output logic [NUM_MASTERS-1:0] gnt_n
);

  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [NUM_MASTERS-1:0] req;
  logic [NUM_MASTERS-1:0] win_oh;
  logic [NUM_MASTERS-1:0] gnt_oh;
  logic [IW-1:0]          win_idx;
  logic [IW-1:0]          served;
  logic                   any_req;

  assign req = ~req_n;

  arb_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick (
    .req_i    (req),
    .base_i   (served),
    .any_o    (any_req),
    .win_idx_o(win_idx),
    .win_oh_o (win_oh)
  );

  arb_grant_reg #(.N(NUM_MASTERS), .IW(IW)) u_gnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_req_i(any_req),
    .win_idx_i(win_idx),
    .win_oh_i (win_oh),
    .gnt_oh_o (gnt_oh)
  );

  arb_bus_monitor #(.N(NUM_MASTERS), .IW(IW)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n_i(frame_n),
    .irdy_n_i (irdy_n),
    .gnt_oh_i (gnt_oh),
    .served_o (served)
  );

  assign gnt_n = ~gnt_oh;

  AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> ((win_oh & req) != '0)); // R5
  AST_WINNER_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) > 1) |-> (win_idx != served)); // R5

endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;

  localparam int N  = 4;
  localparam int NV = 22;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  // Each entry: {req tag, requests (1=asserted), frame asserted, irdy asserted, expected grant (1=asserted)}
  localparam logic [13:0] VEC [0:NV-1] = '{
    {4'd3, 4'b0000, 1'b0, 1'b0, 4'b0001},  // R3 reset holder kept
    {4'd4, 4'b0100, 1'b0, 1'b0, 4'b0000},  // R4 gap before dev2
    {4'd5, 4'b0100, 1'b0, 1'b0, 4'b0100},  // R5 dev2 granted
    {4'd9, 4'b0100, 1'b0, 1'b0, 4'b0100},  // R9 holder keeps grant
    {4'd6, 4'b0100, 1'b1, 1'b0, 4'b0100},  // R6 dev2 starts
    {4'd7, 4'b0110, 1'b1, 1'b0, 4'b0000},  // R7 drop while busy
    {4'd7, 4'b0110, 1'b1, 1'b1, 4'b0010},  // R7 dev1 granted while busy
    {4'd9, 4'b0010, 1'b0, 1'b1, 4'b0010},
    {4'd9, 4'b0010, 1'b0, 1'b0, 4'b0010},
    {4'd6, 4'b0010, 1'b1, 1'b0, 4'b0010},  // R6 dev1 starts
    {4'd3, 4'b0000, 1'b1, 1'b1, 4'b0010},  // R3 park on dev1
    {4'd5, 4'b1001, 1'b1, 1'b1, 4'b0000},  // R5 dev3 beats dev0 after dev1
    {4'd5, 4'b1001, 1'b1, 1'b1, 4'b1000},
    {4'd3, 4'b0000, 1'b0, 1'b0, 4'b1000},
    {4'd4, 4'b0001, 1'b0, 1'b0, 4'b0000},
    {4'd3, 4'b0000, 1'b0, 1'b0, 4'b1000},  // R3 park back on last target
    {4'd4, 4'b0001, 1'b0, 1'b0, 4'b0000},
    {4'd5, 4'b0001, 1'b0, 1'b0, 4'b0001},  // R5 wrap to dev0
    {4'd9, 4'b0001, 1'b0, 1'b0, 4'b0001},
    {4'd6, 4'b0001, 1'b1, 1'b0, 4'b0001},  // R6 dev0 starts
    {4'd8, 4'b1111, 1'b1, 1'b1, 4'b0000},  // R8 requesting holder preempted
    {4'd8, 4'b1111, 1'b1, 1'b1, 4'b0010}
  };

  task automatic check(input int rq, input logic [N-1:0] exp_gnt, input string what);
    n_checks++;
    if (gnt_n !== ~exp_gnt) begin
      n_errors++;
      $display("FAIL R%0d %s: gnt_n actual=%b expected=%b", rq, what, gnt_n, ~exp_gnt);
    end
    n_checks++;
    if ($countones(~gnt_n) > 1) begin
      n_errors++;
      $display("FAIL R1 %s: gnt_n actual=%b expected at most one low", what, gnt_n);
    end
  endtask

  task automatic step(input logic [N-1:0] req, input logic fr, input logic ir);
    req_n   = ~req;
    frame_n = ~fr;
    irdy_n  = ~ir;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    check(2, 4'b0001, "during reset");          // R2
    rst_n = 1'b1;
    @(negedge clk);
    check(2, 4'b0001, "after reset");           // R2

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:6], VEC[i][5], VEC[i][4]);
      check(int'(VEC[i][13:10]), VEC[i][3:0], $sformatf("vector %0d", i));
    end

    // R2: mid-run reset restarts the order at device 0
    rst_n = 1'b0;
    @(negedge clk);
    check(2, 4'b0001, "mid-run reset");
    req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    step(4'b1010, 1'b0, 1'b0);
    check(2, 4'b0000, "order after reset gap");
    step(4'b1010, 1'b0, 1'b0);
    check(2, 4'b0010, "dev1 first after reset");
    step(4'b1011, 1'b0, 1'b0);
    check(2, 4'b0000, "dev0 outranks dev1 after reset");  // served still 3 -> 0 first
    step(4'b1011, 1'b0, 1'b0);
    check(2, 4'b0001, "dev0 granted after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule